// File: doc/BRIEF.md
# Serial Gain-Control Register Interface

This block is the digital front end of a two-channel programmable audio gain array. A host drives three slow wires: a serial clock, a serial data line and an active-low latch strobe. The block samples all three with a fast system clock and shifts a 14-bit control word in, most significant bit first. When the strobe returns high, the staged word is committed to one of two channel registers. Bit D7 of the word selects the register.

Each channel register is decoded continuously into five results. These are a mute flag, a signed gain in dB, an input-enable mask and two 2-bit output-mode codes. A one-cycle update pulse marks every write. Downstream ramp logic uses that pulse to start a click-free change.

The system clock must run at least eight times faster than the serial clock. Every input passes through a two-flop synchronizer, and edges are detected after synchronization.

Top module: `gain_ctrl_if`

## Requirements
- R1: On each rising edge of `ser_clk`, the value on `ser_dat` is shifted into a 14-bit staging register. The first bit sent becomes word bit D13 and the fourteenth becomes D0.
- R2: Channel outputs change only on a rising edge of `ser_ld`. Serial clocking while `ser_ld` is high changes no output. The falling edge of `ser_ld` changes no output.
- R3: On the `ser_ld` rising edge, word bit D7 = 0 writes channel 1 and D7 = 1 writes channel 2. The other channel keeps its contents.
- R4: The gain code is D13..D8, with D13 as the MSB. Code 0 sets mute = 1 and gain = 0. Codes 1 to 49 give mute = 0 and gain = 2·code − 50 dB, so 1 gives −48, 25 gives 0 and 49 gives +48. Codes 50 to 63 give mute = 0 and gain = +48. Gain is an 8-bit two's-complement value.
- R5: On channel 1, `in_sel` bit 0 = D4 (input 1), bit 1 = D5 (input 2) and bit 2 = D6 (input 3). Any combination is accepted.
- R6: On channel 2, `in_sel` bit 0 = D4 and bit 1 = D5. Bit 2 always reads 0, even when D6 = 1.
- R7: `out_b` = D3..D2 and `out_a` = D1..D0, passed through as mode codes. The codes are 00 high impedance, 01 enabled, 10 negative rail and 11 bias level.
- R8: After reset both channels show mute = 1, gain = 0, `in_sel` = 000, `out_b` = `out_a` = 00 and update pulses low. The staging register is cleared.
- R9: Each write raises that channel's update output for exactly one system-clock cycle. The pulse appears in the same cycle as the new decoded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_ld | input | 1 | Latch strobe; word committed on rising edge |
| s1_mute | output | 1 | Channel 1 mute flag |
| s1_gain_db | output | 8 | Channel 1 gain in dB, signed |
| s1_in_sel | output | 3 | Channel 1 input-enable mask |
| s1_out_b | output | 2 | Channel 1 output B mode code |
| s1_out_a | output | 2 | Channel 1 output A mode code |
| s1_upd | output | 1 | Channel 1 write pulse |
| s2_mute | output | 1 | Channel 2 mute flag |
| s2_gain_db | output | 8 | Channel 2 gain in dB, signed |
| s2_in_sel | output | 3 | Channel 2 input-enable mask (bit 2 always 0) |
| s2_out_b | output | 2 | Channel 2 output B mode code |
| s2_out_a | output | 2 | Channel 2 output A mode code |
| s2_upd | output | 1 | Channel 2 write pulse |

## Verification
A slipped or duplicated shift shows up as a rotated word. The gain code, address and mode fields then land in the wrong outputs, and this is visible the first time the strobe rises after that word. A wrong address decode or a missing hold appears in the untouched channel's outputs within a cycle of the strobe. A broken edge detector shows up as a missing, doubled or early update pulse, or as outputs that move on the strobe's falling edge, which is several cycles before the rising one.

// File: rtl/gain_ctrl_if.sv
module gain_ctrl_if #(
  parameter int WORD_W  = 14,
  parameter int SYNC_W  = 2,
  parameter int GAIN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_ld,
  output logic              s1_mute,
  output logic [GAIN_W-1:0] s1_gain_db,
  output logic [2:0]        s1_in_sel,
  output logic [1:0]        s1_out_b,
  output logic [1:0]        s1_out_a,
  output logic              s1_upd,
  output logic              s2_mute,
  output logic [GAIN_W-1:0] s2_gain_db,
  output logic [2:0]        s2_in_sel,
  output logic [1:0]        s2_out_b,
  output logic [1:0]        s2_out_a,
  output logic              s2_upd
);
  localparam int ADDR_BIT  = 7;
  localparam int CODE_LSB  = ADDR_BIT + 1;
  localparam int CODE_W    = WORD_W - CODE_LSB;
  localparam int REG_W     = WORD_W - 1;
  localparam int TOP_CODE  = 49;
  localparam int MAX_DB    = 48;
  localparam int OFFSET_DB = 50;

  logic [SYNC_W:0]   sclk_p, ld_p;
  logic [SYNC_W-1:0] dat_p;
  logic [WORD_W-1:0] shift_q;
  logic [REG_W-1:0]  chan_q [2];
  logic [1:0]        upd_q;

  wire sclk_rise = sclk_p[SYNC_W-1] & ~sclk_p[SYNC_W];
  wire ld_rise   = ld_p[SYNC_W-1] & ~ld_p[SYNC_W];
  wire [REG_W-1:0] word_body = {shift_q[WORD_W-1:CODE_LSB], shift_q[ADDR_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p  <= '0;
      ld_p    <= '1;
      dat_p   <= '0;
      shift_q <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_W-1:0], ser_clk};
      ld_p   <= {ld_p[SYNC_W-1:0], ser_ld};
      dat_p  <= {dat_p[SYNC_W-2:0], ser_dat};
      if (sclk_rise) shift_q <= {shift_q[WORD_W-2:0], dat_p[SYNC_W-1]};
    end
  end

  logic              mute_w [2];
  logic [GAIN_W-1:0] gain_w [2];
  logic [2:0]        sel_w  [2];
  logic [1:0]        ob_w   [2];
  logic [1:0]        oa_w   [2];

  for (genvar c = 0; c < 2; c++) begin : g_chan
    localparam logic [2:0] SEL_MASK = (c == 0) ? 3'b111 : 3'b011;
    wire [CODE_W-1:0] code = chan_q[c][REG_W-1:ADDR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_q[c] <= '0;
        upd_q[c]  <= 1'b0;
      end else begin
        upd_q[c] <= ld_rise & (shift_q[ADDR_BIT] == c[0]);
        if (ld_rise && shift_q[ADDR_BIT] == c[0]) chan_q[c] <= word_body;
      end
    end

    assign mute_w[c] = (code == '0);
    assign gain_w[c] = mute_w[c] ? '0 :
                       (code >= CODE_W'(TOP_CODE)) ? GAIN_W'(MAX_DB) :
                       GAIN_W'({code, 1'b0}) - GAIN_W'(OFFSET_DB);
    assign sel_w[c]  = chan_q[c][6:4] & SEL_MASK;
    assign ob_w[c]   = chan_q[c][3:2];
    assign oa_w[c]   = chan_q[c][1:0];
  end

  assign s1_mute    = mute_w[0];
  assign s1_gain_db = gain_w[0];
  assign s1_in_sel  = sel_w[0];
  assign s1_out_b   = ob_w[0];
  assign s1_out_a   = oa_w[0];
  assign s1_upd     = upd_q[0];
  assign s2_mute    = mute_w[1];
  assign s2_gain_db = gain_w[1];
  assign s2_in_sel  = sel_w[1];
  assign s2_out_b   = ob_w[1];
  assign s2_out_a   = oa_w[1];
  assign s2_upd     = upd_q[1];
endmodule

// File: rtl/gain_ctrl_if_chk.sv
module gain_ctrl_if_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s1_mute,
  input logic [7:0] s1_gain_db,
  input logic [2:0] s1_in_sel,
  input logic [1:0] s1_out_b,
  input logic [1:0] s1_out_a,
  input logic       s1_upd,
  input logic       s2_mute,
  input logic [7:0] s2_gain_db,
  input logic [2:0] s2_in_sel,
  input logic [1:0] s2_out_b,
  input logic [1:0] s2_out_a,
  input logic       s2_upd
);
  assert_hold1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_upd |-> $stable({s1_mute, s1_gain_db, s1_in_sel, s1_out_b, s1_out_a}));
  assert_hold2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_upd |-> $stable({s2_mute, s2_gain_db, s2_in_sel, s2_out_b, s2_out_a}));
  assert_one_chan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(s1_upd && s2_upd));
  assert_gain_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_gain_db[0] && ($signed(s1_gain_db) <= 48) && ($signed(s1_gain_db) >= -48));
  assert_mute_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    s2_mute |-> (s2_gain_db == 8'd0));
  assert_in3_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_in_sel[2]);
  assert_pulse1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s1_upd |=> !s1_upd);
  assert_pulse2_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s2_upd |=> !s2_upd);
endmodule

bind gain_ctrl_if gain_ctrl_if_chk u_chk (.*);

// File: tb/gain_ctrl_if_bench.sv
`timescale 1ns/1ps
module gain_ctrl_if_bench;
  logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_ld = 1;
  logic s1_mute, s1_upd, s2_mute, s2_upd;
  logic [7:0] s1_gain_db, s2_gain_db;
  logic [2:0] s1_in_sel, s2_in_sel;
  logic [1:0] s1_out_b, s1_out_a, s2_out_b, s2_out_a;
  int n_cmp = 0, n_bad = 0, cnt1 = 0, cnt2 = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gain_ctrl_if u_gain_ctrl_if (.*);

  always @(negedge clk) begin
    if (s1_upd) cnt1++;
    if (s2_upd) cnt2++;
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [13:0] mk(int code, bit addr, logic [2:0] sel, logic [1:0] ob, logic [1:0] oa);
    return {6'(code), addr, sel, ob, oa};
  endfunction

  function automatic int exp_gain(int code);
    if (code == 0) return 0;
    if (code >= 49) return 48;
    return 2 * code - 50;
  endfunction

  task automatic shift_word(logic [13:0] w);
    for (int i = 13; i >= 0; i--) begin
      ser_dat = w[i]; wait_clk(8);
      ser_clk = 1;    wait_clk(8);
      ser_clk = 0;    wait_clk(8);
    end
  endtask

  task automatic strobe();
    cnt1 = 0; cnt2 = 0;
    ser_ld = 0; wait_clk(10);
    ser_ld = 1; wait_clk(10);
  endtask

  task automatic chk_chan(string req, int ch, int code, logic [2:0] sel, logic [1:0] ob, logic [1:0] oa);
    if (ch == 1) begin
      chk({req, " ch1 mute"}, s1_mute, code == 0);
      chk({req, " ch1 gain"}, $signed(s1_gain_db), exp_gain(code));
      chk({req, " ch1 sel"}, s1_in_sel, sel);
      chk({req, " ch1 outb"}, s1_out_b, ob);
      chk({req, " ch1 outa"}, s1_out_a, oa);
    end else begin
      chk({req, " ch2 mute"}, s2_mute, code == 0);
      chk({req, " ch2 gain"}, $signed(s2_gain_db), exp_gain(code));
      chk({req, " ch2 sel"}, s2_in_sel, sel & 3'b011);
      chk({req, " ch2 outb"}, s2_out_b, ob);
      chk({req, " ch2 outa"}, s2_out_a, oa);
    end
  endtask

  task automatic t_reset();
    chk_chan("R8 reset", 1, 0, 3'b000, 2'b00, 2'b00);
    chk_chan("R8 reset", 2, 0, 3'b000, 2'b00, 2'b00);
    chk("R8 reset upd1", s1_upd, 0);
    chk("R8 reset upd2", s2_upd, 0);
  endtask

  task automatic t_ch1_write();
    shift_word(mk(25, 0, 3'b101, 2'b01, 2'b11));
    chk_chan("R2 shift only", 1, 0, 3'b000, 2'b00, 2'b00);
    ser_ld = 0; wait_clk(10);
    chk_chan("R2 falling edge", 1, 0, 3'b000, 2'b00, 2'b00);
    chk("R2 falling no upd", cnt1, 0);
    ser_ld = 1; wait_clk(10);
    chk_chan("R1 R5 R7 ch1 write", 1, 25, 3'b101, 2'b01, 2'b11);
    chk_chan("R3 ch2 kept", 2, 0, 3'b000, 2'b00, 2'b00);
    chk("R9 ch1 one pulse", cnt1, 1);
    chk("R3 ch2 no pulse", cnt2, 0);
  endtask

  task automatic t_ch2_write();
    shift_word(mk(37, 1, 3'b111, 2'b10, 2'b01));
    strobe();
    chk_chan("R6 R3 ch2 write", 2, 37, 3'b111, 2'b10, 2'b01);
    chk_chan("R3 ch1 kept", 1, 25, 3'b101, 2'b01, 2'b11);
    chk("R9 ch2 one pulse", cnt2, 1);
    chk("R3 ch1 no pulse", cnt1, 0);
  endtask

  task automatic t_gain_sweep();
    int codes[7] = '{0, 1, 24, 49, 50, 51, 63};
    foreach (codes[k]) begin
      shift_word(mk(codes[k], 0, 3'(k), 2'(k), 2'(k + 1)));
      strobe();
      chk_chan("R4 gain code", 1, codes[k], 3'(k), 2'(k), 2'(k + 1));
    end
  endtask

  task automatic t_sel_none_ch2();
    shift_word(mk(2, 1, 3'b100, 2'b11, 2'b00));
    strobe();
    chk_chan("R6 ch2 in3 only", 2, 2, 3'b100, 2'b11, 2'b00);
    chk("R6 ch2 sel zero", s2_in_sel, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    wait_clk(5);
    t_reset();
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_ch1_write();
    t_ch2_write();
    t_gain_sweep();
    t_sel_none_ch2();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule